// File: doc/BRIEF.md
# Indexed Read Stream Address Queue

This unit is the per-lane front end for a small set of indexed read streams into a banked scratch storage. Each stream has its own queue of record addresses written by the compute cluster. A record is a base word address and a length. The queue head holds a word offset counter, so a record becomes a run of single-word requests, one per issue, without further work from the cluster.

The storage bank is split into sub-arrays, and each sub-array serves one word per cycle. A local arbiter chooses, for every sub-array, one stream among those whose head word falls there. The choice rotates round-robin. Streams that lose keep their head and try again in the next cycle, together with any other requests that do not conflict. The local choice is formed at once, in parallel with the global port arbitration. It only takes effect in a cycle where the global arbiter hands the port to the indexed streams.

Read data comes back a fixed number of cycles after the request. It is steered into a per-stream data buffer in issue order. The cluster pops words from these buffers, and a pop from an empty buffer raises a stall.

Top module: `isq_lane_unit`

## Requirements
- R1: Each address queue holds FIFO_DEPTH records (default 8). `ready_o[s]` is low while queue s is full, and a push into a full queue is dropped: the record is never requested.
- R2: A record with length field L (the word count minus one) issues word addresses base, base+1, ..., base+L from stream s in consecutive issues of that stream.
- R3: Per cycle, each stream issues at most one word, and each sub-array receives at most one request.
- R4: When several streams head to the same sub-array, one of them is issued. Each loser keeps its head word and is offered again in the next cycle, next to other non-conflicting requests.
- R5: The winner for each sub-array is chosen round-robin. The search starts after the stream last granted on that sub-array, and from stream 0 after reset.
- R6: A head word that is not issued holds back every later word of its queue (head-of-line blocking).
- R7: Local grants are formed whether or not `idx_win_i` is high. With `idx_win_i` low, no request leaves, and no queue or arbitration state moves.
- R8: A request issued in cycle t returns on `sub_rdata_i` in cycle t+RD_LAT. The word can be popped from cycle t+RD_LAT+1 on, and each stream's words pop in issue order.
- R9: `stall_o` is high in any cycle where `pop_i[s]` is high for an empty buffer of stream s. Such a pop removes nothing.
- R10: A stream issues only while its issued-but-unpopped word count is below BUF_DEPTH, so a data buffer never overflows.
- R11: The sub-array of a word address is its low log2(NUM_SUBS) bits. `sub_row_o[k]` carries the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | NUM_STREAMS | Record push, one bit per stream |
| push_addr_i | input | NUM_STREAMS x ADDR_W | Record base word address per stream |
| push_len_i | input | NUM_STREAMS x LEN_W | Record word count minus one per stream |
| ready_o | output | NUM_STREAMS | Address queue has room |
| idx_win_i | input | 1 | Global arbiter gives the port to indexed streams this cycle |
| sub_req_o | output | NUM_SUBS | Word request per sub-array |
| sub_row_o | output | NUM_SUBS x (ADDR_W - log2 NUM_SUBS) | Row address per sub-array |
| sub_rdata_i | input | NUM_SUBS x DATA_W | Read data per sub-array, RD_LAT cycles after the request |
| pop_i | input | NUM_STREAMS | Cluster pop per stream buffer |
| pop_data_o | output | NUM_STREAMS x DATA_W | Head word of each stream buffer |
| stall_o | output | 1 | A pop targets an empty buffer |

## Verification
A pushed record becomes a head one cycle after its push edge. Its request appears on `sub_req_o` in that same cycle, with no register between the grant and the port. The returned word can be popped RD_LAT+1 cycles after the issue cycle. The directed cases count these edges one by one and check stall high on the cycles before the data is due and low on the cycle it is due. Inputs change on the falling edge, and outputs are sampled 1 ns later, so each check sees the state after the preceding rising edge. The random phase checks only the order and value of popped words against a per-stream model queue, because exact arbitration timing is not predicted there.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int unsigned STREAMS_DEF    = 3;
  localparam int unsigned SUBS_DEF       = 4;
  localparam int unsigned ADDR_W_DEF     = 8;
  localparam int unsigned LEN_W_DEF      = 2;
  localparam int unsigned DATA_W_DEF     = 16;
  localparam int unsigned FIFO_DEPTH_DEF = 8;
  localparam int unsigned BUF_DEPTH_DEF  = 8;
  localparam int unsigned RD_LAT_DEF     = 2;
endpackage

// File: rtl/isq_addr_fifo.sv
module isq_addr_fifo
  import isq_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned LEN_W  = LEN_W_DEF,
  parameter int unsigned DEPTH  = FIFO_DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [LEN_W-1:0]  push_len_i,
  output logic              ready_o,
  output logic              head_vld_o,
  output logic [ADDR_W-1:0] word_addr_o,
  input  logic              issue_i
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic [LEN_W-1:0]  off_q;
  logic              full, do_push, last_word, rec_done;

  assign full        = (cnt_q == CW'(DEPTH));
  assign ready_o     = ~full;
  assign head_vld_o  = (cnt_q != '0);
  assign do_push     = push_i & ~full;
  assign last_word   = (off_q == len_q[rp_q]);
  assign rec_done    = issue_i & last_word;
  assign word_addr_o = addr_q[rp_q] + ADDR_W'(off_q);

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      addr_q[wp_q] <= push_addr_i;
      len_q[wp_q]  <= push_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      off_q <= '0;
    end else begin
      if (do_push)  wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (rec_done) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(rec_done);
      if (issue_i) off_q <= last_word ? '0 : off_q + 1'b1;
    end
  end

  AST_ISSUE_HAS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> head_vld_o);  // R3
  AST_FULL_PUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !rec_done) |=> (cnt_q == $past(cnt_q)));  // R1
  AST_HEAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_vld_o && !issue_i) |=> (head_vld_o && $stable(word_addr_o)));  // R6
endmodule

// File: rtl/isq_rr_arb.sv
module isq_rr_arb
  import isq_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = STREAMS_DEF,
  parameter int unsigned NUM_SUBS    = SUBS_DEF,
  localparam int unsigned SW = $clog2(NUM_SUBS),
  localparam int unsigned IW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_STREAMS-1:0]          elig_i,
  input  logic [NUM_STREAMS-1:0][SW-1:0]  sub_i,
  input  logic                            win_i,
  output logic [NUM_STREAMS-1:0]          gnt_o
);
  logic [NUM_SUBS-1:0][IW-1:0] ptr_q, pick;
  logic [NUM_SUBS-1:0]         hit;

  // speculative: independent of win_i
  always_comb begin
    gnt_o = '0;
    hit   = '0;
    pick  = '0;
    for (int k = 0; k < NUM_SUBS; k++) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        int idx;
        idx = (int'(ptr_q[k]) + i) % NUM_STREAMS;
        if (!hit[k] && elig_i[idx] && (sub_i[idx] == SW'(k))) begin
          gnt_o[idx] = 1'b1;
          hit[k]     = 1'b1;
          pick[k]    = IW'(idx);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (win_i) begin
      for (int k = 0; k < NUM_SUBS; k++)
        if (hit[k]) ptr_q[k] <= (pick[k] == IW'(NUM_STREAMS - 1)) ? '0 : pick[k] + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_SUBS; k++) begin : g_chk
    logic [NUM_STREAMS-1:0] col;
    always_comb
      for (int s = 0; s < NUM_STREAMS; s++) col[s] = gnt_o[s] && (sub_i[s] == SW'(k));
    AST_ONE_PER_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));  // R3
    AST_RR_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_i && hit[k]) |=> (ptr_q[k] != $past(pick[k])));  // R5
  end

  AST_NO_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_i |=> $stable(ptr_q));  // R7
endmodule

// File: rtl/isq_data_buf.sv
module isq_data_buf
  import isq_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned DEPTH  = BUF_DEPTH_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic              space_o,
  output logic              empty_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     occ_q, resv_q;
  logic              do_pop;

  assign empty_o   = (occ_q == '0);
  assign do_pop    = pop_i & ~empty_o;
  assign space_o   = (resv_q < CW'(DEPTH));
  assign rd_data_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      occ_q  <= '0;
      resv_q <= '0;
    end else begin
      if (wr_i)   wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      occ_q  <= occ_q + CW'(wr_i) - CW'(do_pop);
      resv_q <= resv_q + CW'(issue_i) - CW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> (occ_q < CW'(DEPTH)));  // R10
  AST_ISSUE_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> space_o);  // R10
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> (occ_q == $past(occ_q) + CW'($past(wr_i))));  // R9
endmodule

// File: rtl/isq_lane_unit.sv
module isq_lane_unit
  import isq_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = STREAMS_DEF,
  parameter int unsigned NUM_SUBS    = SUBS_DEF,
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned LEN_W       = LEN_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned FIFO_DEPTH  = FIFO_DEPTH_DEF,
  parameter int unsigned BUF_DEPTH   = BUF_DEPTH_DEF,
  parameter int unsigned RD_LAT      = RD_LAT_DEF,
  localparam int unsigned SW = $clog2(NUM_SUBS),
  localparam int unsigned RW = ADDR_W - SW
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_STREAMS-1:0]              push_i,
  input  logic [NUM_STREAMS-1:0][ADDR_W-1:0]  push_addr_i,
  input  logic [NUM_STREAMS-1:0][LEN_W-1:0]   push_len_i,
  output logic [NUM_STREAMS-1:0]              ready_o,
  input  logic                                idx_win_i,
  output logic [NUM_SUBS-1:0]                 sub_req_o,
  output logic [NUM_SUBS-1:0][RW-1:0]         sub_row_o,
  input  logic [NUM_SUBS-1:0][DATA_W-1:0]     sub_rdata_i,
  input  logic [NUM_STREAMS-1:0]              pop_i,
  output logic [NUM_STREAMS-1:0][DATA_W-1:0]  pop_data_o,
  output logic                                stall_o
);
  localparam int unsigned IW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1;

  logic [NUM_STREAMS-1:0]             head_vld, space, elig, gnt, issue, wr, empty;
  logic [NUM_STREAMS-1:0][ADDR_W-1:0] waddr;
  logic [NUM_STREAMS-1:0][SW-1:0]     sub;
  logic [NUM_STREAMS-1:0][DATA_W-1:0] wdata;
  logic [NUM_SUBS-1:0][IW-1:0]        req_sid;
  logic [RD_LAT-1:0][NUM_SUBS-1:0]          tv_q;
  logic [RD_LAT-1:0][NUM_SUBS-1:0][IW-1:0]  ts_q;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_strm
    isq_addr_fifo #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i, .rst_ni,
      .push_i(push_i[s]), .push_addr_i(push_addr_i[s]), .push_len_i(push_len_i[s]),
      .ready_o(ready_o[s]), .head_vld_o(head_vld[s]), .word_addr_o(waddr[s]),
      .issue_i(issue[s]));
    isq_data_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk_i, .rst_ni,
      .issue_i(issue[s]), .wr_i(wr[s]), .wr_data_i(wdata[s]),
      .pop_i(pop_i[s]), .space_o(space[s]), .empty_o(empty[s]),
      .rd_data_o(pop_data_o[s]));
    assign sub[s] = waddr[s][SW-1:0];
  end

  assign elig  = head_vld & space;
  assign issue = gnt & {NUM_STREAMS{idx_win_i}};

  isq_rr_arb #(.NUM_STREAMS(NUM_STREAMS), .NUM_SUBS(NUM_SUBS)) u_arb (
    .clk_i, .rst_ni, .elig_i(elig), .sub_i(sub), .win_i(idx_win_i), .gnt_o(gnt));

  always_comb begin
    sub_req_o = '0;
    sub_row_o = '0;
    req_sid   = '0;
    for (int k = 0; k < NUM_SUBS; k++)
      for (int s = 0; s < NUM_STREAMS; s++)
        if (issue[s] && (sub[s] == SW'(k))) begin
          sub_req_o[k] = 1'b1;
          sub_row_o[k] = waddr[s][ADDR_W-1:SW];
          req_sid[k]   = IW'(s);
        end
  end

  // stream tags travel alongside the fixed read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tv_q <= '0;
      ts_q <= '0;
    end else begin
      tv_q[0] <= sub_req_o;
      ts_q[0] <= req_sid;
      for (int l = 1; l < RD_LAT; l++) begin
        tv_q[l] <= tv_q[l-1];
        ts_q[l] <= ts_q[l-1];
      end
    end
  end

  always_comb begin
    wr    = '0;
    wdata = '0;
    for (int k = 0; k < NUM_SUBS; k++)
      if (tv_q[RD_LAT-1][k]) begin
        wr[ts_q[RD_LAT-1][k]]    = 1'b1;
        wdata[ts_q[RD_LAT-1][k]] = sub_rdata_i[k];
      end
  end

  assign stall_o = |(pop_i & empty);

  always_ff @(posedge clk_i) begin
    if (rst_ni)
      for (int k = 0; k < NUM_SUBS; k++)
        for (int j = k + 1; j < NUM_SUBS; j++)
          AST_RET_UNIQUE: assert (!(tv_q[RD_LAT-1][k] && tv_q[RD_LAT-1][j] &&
                                   (ts_q[RD_LAT-1][k] == ts_q[RD_LAT-1][j])));  // R8
  end

  AST_ISSUE_NEEDS_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|issue) |-> idx_win_i);  // R7
endmodule

// File: tb/isq_lane_unit_test.sv
`timescale 1ns/1ps
module isq_lane_unit_test;
  localparam int NS = 3, NSUB = 4, AW = 8, LW = 2, DW = 16, LAT = 2;
  localparam int SW = 2, RW = AW - SW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NS-1:0] push_i, ready_o, pop_i;
  logic [NS-1:0][AW-1:0] push_addr_i;
  logic [NS-1:0][LW-1:0] push_len_i;
  logic idx_win_i, stall_o;
  logic [NSUB-1:0] sub_req_o;
  logic [NSUB-1:0][RW-1:0] sub_row_o;
  logic [NSUB-1:0][DW-1:0] sub_rdata_i;
  logic [NS-1:0][DW-1:0] pop_data_o;

  int tests = 0, fails = 0;
  logic [AW-1:0] sbq [NS][64];
  int hd [NS], tl [NS];

  always #2.5 clk = ~clk;

  isq_lane_unit uut (
    .clk_i(clk), .rst_ni, .push_i, .push_addr_i, .push_len_i, .ready_o,
    .idx_win_i, .sub_req_o, .sub_row_o, .sub_rdata_i, .pop_i, .pop_data_o, .stall_o);

  function automatic logic [DW-1:0] fdata(logic [AW-1:0] a);
    return {~a, a};
  endfunction

  // storage model: fixed latency LAT
  logic [LAT-1:0][NSUB-1:0][RW-1:0] mrow;
  always @(posedge clk) begin
    mrow[0] <= sub_row_o;
    for (int l = 1; l < LAT; l++) mrow[l] <= mrow[l-1];
  end
  always_comb
    for (int k = 0; k < NSUB; k++) sub_rdata_i[k] = fdata({mrow[LAT-1][k], SW'(k)});

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic pop_chk(input int s, input logic [AW-1:0] a, input string rq);
    @(negedge clk);
    push_i = '0;
    pop_i = '0;
    pop_i[s] = 1'b1;
    #1;
    chk(!stall_o && pop_data_o[s] == fdata(a), rq, {stall_o, pop_data_o[s]}, fdata(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    push_i = '0; push_addr_i = '0; push_len_i = '0; pop_i = '0; idx_win_i = 1'b0;
    for (int s = 0; s < NS; s++) begin hd[s] = 0; tl[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk(ready_o == '1, "R1 reset ready", ready_o, 3'b111);
    chk(sub_req_o == '0, "R7 reset req", sub_req_o, 0);
    chk(stall_o == 1'b0, "R9 reset stall", stall_o, 0);

    // conflict on sub-array 0, second stream retried
    @(negedge clk);
    push_i = 3'b111;
    push_addr_i[0] = 8'h04; push_len_i[0] = 2'd0;
    push_addr_i[1] = 8'h08; push_len_i[1] = 2'd0;
    push_addr_i[2] = 8'h11; push_len_i[2] = 2'd1;
    @(negedge clk); push_i = '0; #1;
    chk(sub_req_o == '0, "R7 no win no req", sub_req_o, 0);
    @(negedge clk); idx_win_i = 1'b1; #1;
    chk(sub_req_o == 4'b0011, "R3 req vector", sub_req_o, 4'b0011);
    chk(sub_row_o[0] == 6'd1, "R5 stream0 first", sub_row_o[0], 1);
    chk(sub_row_o[1] == 6'd4, "R11 row split", sub_row_o[1], 4);
    @(negedge clk); #1;
    chk(sub_req_o == 4'b0101, "R4 retry with new", sub_req_o, 4'b0101);
    chk(sub_row_o[0] == 6'd2, "R4 loser row", sub_row_o[0], 2);
    chk(sub_row_o[2] == 6'd4, "R2 second word", sub_row_o[2], 4);
    @(negedge clk); pop_i = 3'b010; #1;
    chk(sub_req_o == '0, "R2 record ended", sub_req_o, 0);
    chk(stall_o == 1'b1, "R9 empty pop stall", stall_o, 1);
    @(negedge clk); #1;
    chk(stall_o == 1'b1, "R8 not yet due", stall_o, 1);
    @(negedge clk); #1;
    chk(!stall_o && pop_data_o[1] == fdata(8'h08), "R8 due at LAT+1", pop_data_o[1], fdata(8'h08));
    pop_chk(0, 8'h04, "R8 stream0 data");
    pop_chk(2, 8'h11, "R8 order word0");
    pop_chk(2, 8'h12, "R2 order word1");
    @(negedge clk); pop_i = 3'b100; #1;
    chk(stall_o == 1'b1, "R9 drained stall", stall_o, 1);
    @(negedge clk); pop_i = '0;

    // full queue, dropped push
    idx_win_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0 || i == 7) begin #1; chk(ready_o[0], "R1 ready before full", ready_o[0], 1); end
      push_i = 3'b001; push_addr_i[0] = AW'(8'h20 + 4 * i); push_len_i[0] = 2'd0;
    end
    @(negedge clk); #1;
    chk(!ready_o[0], "R1 full not ready", ready_o[0], 0);
    push_addr_i[0] = 8'h80;
    @(negedge clk); push_i = '0; idx_win_i = 1'b1;
    repeat (14) @(negedge clk);
    for (int i = 0; i < 8; i++) pop_chk(0, AW'(8'h20 + 4 * i), "R8 full drain");
    @(negedge clk); pop_i = 3'b001; #1;
    chk(stall_o == 1'b1, "R1 dropped push absent", stall_o, 1);

    // head-of-line blocking and rotation
    @(negedge clk); pop_i = '0; idx_win_i = 1'b0;
    push_i = 3'b110; push_addr_i[1] = 8'h0C; push_len_i[1] = 2'd0;
    push_addr_i[2] = 8'h00; push_len_i[2] = 2'd0;
    @(negedge clk); push_i = 3'b100; push_addr_i[2] = 8'h05;
    @(negedge clk); push_i = '0; idx_win_i = 1'b1; #1;
    chk(sub_req_o == 4'b0001, "R6 later entry held", sub_req_o, 4'b0001);
    chk(sub_row_o[0] == 6'd3, "R5 rotated winner", sub_row_o[0], 3);
    @(negedge clk); #1;
    chk(sub_req_o == 4'b0001 && sub_row_o[0] == 6'd0, "R4 head retried", sub_row_o[0], 0);
    @(negedge clk); #1;
    chk(sub_req_o == 4'b0010 && sub_row_o[1] == 6'd1, "R6 released", sub_req_o, 4'b0010);
    repeat (4) @(negedge clk);
    pop_chk(1, 8'h0C, "R8 hol s1");
    pop_chk(2, 8'h00, "R8 hol s2 a");
    pop_chk(2, 8'h05, "R8 hol s2 b");

    // random phase
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 3000; n++) begin
      int ps;
      @(negedge clk);
      push_i = '0;
      for (int s = 0; s < NS; s++) begin
        if ($urandom % 3 == 0) begin
          logic [AW-1:0] a;
          logic [LW-1:0] l;
          a = AW'($urandom); l = LW'($urandom);
          push_i[s] = 1'b1; push_addr_i[s] = a; push_len_i[s] = l;
          if (ready_o[s])
            for (int w = 0; w <= int'(l); w++) begin
              sbq[s][tl[s] % 64] = a + AW'(w); tl[s]++;
            end
        end
      end
      idx_win_i = ($urandom % 4) != 0;
      ps = $urandom % (NS + 1);
      pop_i = '0;
      if (ps < NS) pop_i[ps] = 1'b1;
      #1;
      if (ps < NS && !stall_o) begin
        chk(hd[ps] != tl[ps] && pop_data_o[ps] == fdata(sbq[ps][hd[ps] % 64]),
            "R8 random order", pop_data_o[ps], fdata(sbq[ps][hd[ps] % 64]));
        hd[ps]++;
      end
    end
    @(negedge clk); push_i = '0; idx_win_i = 1'b1; pop_i = '0;
    for (int n = 0; n < 3000; n++) begin
      int ps;
      if (hd[0] == tl[0] && hd[1] == tl[1] && hd[2] == tl[2]) break;
      @(negedge clk);
      ps = n % NS;
      pop_i = '0; pop_i[ps] = 1'b1;
      #1;
      if (!stall_o) begin
        chk(hd[ps] != tl[ps] && pop_data_o[ps] == fdata(sbq[ps][hd[ps] % 64]),
            "R10 drain order", pop_data_o[ps], fdata(sbq[ps][hd[ps] % 64]));
        hd[ps]++;
      end
    end
    @(negedge clk); pop_i = '0;
    chk(hd[0] == tl[0] && hd[1] == tl[1] && hd[2] == tl[2], "R8 all words returned",
        hd[0] + hd[1] + hd[2], tl[0] + tl[1] + tl[2]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule